// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Sequencing

This block keeps an SDRAM's contents alive by issuing auto-refresh commands at a steady interval. A prescaler divides the clock down to one refresh tick per interval, for example one tick every 15.6 µs so that 4096 rows are covered in 64 ms. Each tick becomes one pending refresh. A pending refresh is issued only while the memory controller reports every bank idle and the device out of power-down. Ticks that arrive while the bus is blocked are held in a small saturating counter. An urgent flag tells the controller when that counter is full, so that it can close its banks.

The block also moves the device into and out of self-refresh. A request that arrives with the banks idle produces the self-refresh entry command and takes CKE low. This request wins over any queued refresh, and the queue is emptied. When the request is withdrawn, CKE is raised and a quiet period of tRC cycles follows. A burst of back-to-back refreshes, each tRC apart, can optionally come next.

After every refresh the block drives NOPs and reports itself busy for tRC cycles. During that time the controller must not use the command pins.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With `all_idle`=1 and `pwr_down`=0, the block issues exactly one auto refresh per tick. Ticks occur every TICK_DIV clock cycles, so consecutive refreshes are exactly TICK_DIV cycles apart.
- R2: Ticks that cannot be served are stored, up to PEND_MAX (8). Further ticks are dropped. Once the bus is free, every stored tick is served.
- R3: `urgent` is 1 exactly while the stored count equals PEND_MAX, and 0 otherwise.
- R4: An auto refresh is driven only when `all_idle`=1 and `pwr_down`=0 in the cycle before it. It is encoded as {cs_n,ras_n,cas_n,we_n}=4'b0001 with `cke`=1.
- R5: After any command, at least TRC cycles pass before the next non-NOP command. NOP is encoded as {cs_n,ras_n,cas_n,we_n}=4'b0111. `busy` is 1 while the block holds the bus after a refresh and 0 once it has released it.
- R6: Self-refresh entry requires `sr_req`=1, `all_idle`=1 and `pwr_down`=0. It is encoded as pins 4'b0001 with `cke`=0 in the same cycle. A pending refresh does not delay it.
- R7: While in self-refresh, `cke` stays 0, only NOPs are driven, and refresh ticks are ignored.
- R8: When `sr_req` falls, `cke` returns to 1 in the next cycle. No command follows within TRC cycles of the first cycle with `cke` high.
- R9: Self-refresh entry clears all stored ticks. After an exit without a burst, the next refresh comes only from the next tick.
- R10: If `burst_mode`=1 when the exit quiet period ends, BURST_COUNT refreshes are issued. The first comes TRC cycles after `cke` rises, and each later one comes TRC cycles after the previous one.
- R11: Out of reset, the pins show NOP, `cke`=1, `busy`=0 and `urgent`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| all_idle | input | 1 | Controller reports that every bank is precharged |
| pwr_down | input | 1 | Controller reports that the device is in power-down |
| sr_req | input | 1 | Level request to stay in self-refresh |
| burst_mode | input | 1 | Issue a refresh burst after self-refresh exit |
| cs_n | output | 1 | Chip select command pin |
| ras_n | output | 1 | Row strobe command pin |
| cas_n | output | 1 | Column strobe command pin |
| we_n | output | 1 | Write enable command pin |
| cke | output | 1 | Clock enable |
| busy | output | 1 | Scheduler owns the command pins |
| urgent | output | 1 | Stored refresh count is saturated |

## Verification
The properties assume that the controller is the only other party on the command pins and that it stays off them while `busy` is high. Because of that, every non-NOP code seen on the pins is attributed to the scheduler. They also take `all_idle` and `pwr_down` as truthful, one-cycle-registered reports. The bench acts as that controller: it changes `all_idle`, `pwr_down` and `sr_req` only at fixed offsets within the refresh period, learned from the first refresh. This keeps each gated window a whole number of ticks long and keeps each observation window clear of the next tick.

// File: rtl/refr_pkg.sv
package refr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SREF,
    ST_SRX,
    ST_BURST
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  // Auto refresh and self-refresh entry share pins; CKE tells them apart.
  localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic logic bus_free(input logic idle, input logic pdown);
    return idle && !pdown;
  endfunction

  // Saturating pending-tick arithmetic; clear wins over everything.
  function automatic int unsigned pend_next(input int unsigned cur, input int unsigned cap,
                                            input logic inc, input logic dec, input logic clr);
    if (clr) return 0;
    if (inc && !dec) return (cur < cap) ? cur + 1 : cur;
    if (dec && !inc) return (cur > 0) ? cur - 1 : 0;
    return cur;
  endfunction

endpackage

// File: rtl/refr_tick_gen.sv
module refr_tick_gen #(
  parameter int TICK_DIV = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/refr_pend_ctr.sv
module refr_pend_ctr #(
  parameter int PEND_MAX = 8,
  parameter int PW       = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [PW-1:0] pend,
  output logic          full
);
  import refr_pkg::*;

  logic [PW-1:0] pend_q;

  assign pend = pend_q;
  assign full = (pend_q == PW'(PEND_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= PW'(pend_next(int'(pend_q), PEND_MAX, inc, dec, clr));
  end
endmodule

// File: rtl/refr_seq_fsm.sv
module refr_seq_fsm #(
  parameter int TRC         = 7,
  parameter int BURST_COUNT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              all_idle,
  input  logic              pwr_down,
  input  logic              sr_req,
  input  logic              burst_mode,
  input  logic              pend_nz,
  output refr_pkg::sd_cmd_t cmd,
  output logic              cke,
  output logic              busy,
  output logic              ar_fire,
  output logic              sr_enter,
  output logic              in_selfref,
  output logic              burst_act
);
  import refr_pkg::*;

  localparam int TW = $clog2(TRC + 1);
  localparam int BW = $clog2(BURST_COUNT + 1);

  seq_state_t    st_q;
  logic [TW-1:0] tmr_q;
  logic [BW-1:0] bcnt_q;
  sd_cmd_t       cmd_q;
  logic          cke_q;
  logic          free_w;
  logic          tmr_last;

  assign free_w     = bus_free(all_idle, pwr_down);
  assign sr_enter   = (st_q == ST_IDLE) && sr_req && free_w;
  assign ar_fire    = (st_q == ST_IDLE) && pend_nz && free_w && !sr_enter;
  assign tmr_last   = (tmr_q == TW'(1));
  assign in_selfref = (st_q == ST_SREF) || (st_q == ST_SRX) || (st_q == ST_BURST);
  assign burst_act  = (st_q == ST_BURST);
  assign busy       = (st_q != ST_IDLE);
  assign cmd        = cmd_q;
  assign cke        = cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      bcnt_q <= '0;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b1;
    end else begin
      cmd_q <= CMD_NOP;
      case (st_q)
        ST_IDLE: begin
          if (sr_enter) begin
            cmd_q <= CMD_REF;
            cke_q <= 1'b0;
            st_q  <= ST_SREF;
          end else if (ar_fire) begin
            cmd_q <= CMD_REF;
            tmr_q <= TW'(TRC);
            st_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          tmr_q <= tmr_q - TW'(1);
          if (tmr_last) st_q <= ST_IDLE;
        end
        ST_SREF: begin
          if (!sr_req) begin
            cke_q <= 1'b1;
            tmr_q <= TW'(TRC);
            st_q  <= ST_SRX;
          end
        end
        ST_SRX: begin
          tmr_q <= tmr_q - TW'(1);
          if (tmr_last) begin
            if (burst_mode) begin
              cmd_q  <= CMD_REF;
              tmr_q  <= TW'(TRC);
              bcnt_q <= BW'(BURST_COUNT - 1);
              st_q   <= ST_BURST;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_BURST: begin
          tmr_q <= tmr_q - TW'(1);
          if (tmr_last) begin
            if (bcnt_q == '0) begin
              st_q <= ST_IDLE;
            end else begin
              cmd_q  <= CMD_REF;
              tmr_q  <= TW'(TRC);
              bcnt_q <= bcnt_q - BW'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int TICK_DIV    = 1560,
  parameter int TRC         = 7,
  parameter int PEND_MAX    = 8,
  parameter int BURST_COUNT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_idle,
  input  logic pwr_down,
  input  logic sr_req,
  input  logic burst_mode,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic busy,
  output logic urgent
);
  import refr_pkg::*;

  localparam int PW = $clog2(PEND_MAX + 1);

  logic          tick;
  logic          tick_take;
  logic          ar_fire;
  logic          sr_enter;
  logic          in_selfref;
  logic          burst_act;
  logic [PW-1:0] pend_cnt;
  sd_cmd_t       cmd;

  refr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  // Self-refresh keeps rows alive internally, so ticks are not banked then.
  assign tick_take = tick && !in_selfref;

  refr_pend_ctr #(.PEND_MAX(PEND_MAX), .PW(PW)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (tick_take),
    .dec  (ar_fire),
    .clr  (sr_enter),
    .pend (pend_cnt),
    .full (urgent)
  );

  refr_seq_fsm #(.TRC(TRC), .BURST_COUNT(BURST_COUNT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_idle  (all_idle),
    .pwr_down  (pwr_down),
    .sr_req    (sr_req),
    .burst_mode(burst_mode),
    .pend_nz   (pend_cnt != '0),
    .cmd       (cmd),
    .cke       (cke),
    .busy      (busy),
    .ar_fire   (ar_fire),
    .sr_enter  (sr_enter),
    .in_selfref(in_selfref),
    .burst_act (burst_act)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/refr_sched_chk.sv
module refr_sched_chk #(
  parameter int TRC      = 7,
  parameter int PEND_MAX = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          all_idle,
  input logic          pwr_down,
  input logic          sr_req,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          cke,
  input logic [PW-1:0] pend_cnt,
  input logic          burst_act,
  input logic          in_selfref
);
  localparam int SW = $clog2(TRC + 1);

  logic          pins_nop;
  logic          pins_refpat;
  logic          cke_d;
  logic [SW-1:0] since_q;

  assign pins_nop    = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign pins_refpat = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);

  // Cycles since the last command or CKE rise, saturating at TRC.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_d   <= 1'b1;
      since_q <= SW'(TRC);
    end else begin
      cke_d <= cke;
      if (!pins_nop || (cke && !cke_d)) since_q <= SW'(1);
      else if (since_q < SW'(TRC))      since_q <= since_q + SW'(1);
    end
  end

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= PEND_MAX);  // R2
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt != $past(pend_cnt)) |-> (int'(pend_cnt) == int'($past(pend_cnt)) + 1 || int'(pend_cnt) + 1 == int'($past(pend_cnt)) || pend_cnt == '0));  // R2
  AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_refpat && cke && !burst_act) |-> $past(all_idle && !pwr_down));  // R4
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_nop |-> (int'(since_q) >= TRC));  // R5
  AST_SRE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_refpat && !cke && cke_d) |-> $past(all_idle && !pwr_down && sr_req));  // R6
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cke_d) |-> pins_nop);  // R7
  AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cke_d) |-> pins_nop);  // R8
  AST_SR_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_selfref |-> (pend_cnt == '0));  // R9
endmodule

bind sdram_refresh_sched refr_sched_chk #(.TRC(TRC), .PEND_MAX(PEND_MAX), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .all_idle  (all_idle),
  .pwr_down  (pwr_down),
  .sr_req    (sr_req),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .cke       (cke),
  .pend_cnt  (pend_cnt),
  .burst_act (burst_act),
  .in_selfref(in_selfref)
);

// File: tb/sim_sdram_refresh_sched.sv
`timescale 1ns/1ps
module sim_sdram_refresh_sched;
  localparam int TICK_DIV    = 40;
  localparam int TRC         = 3;
  localparam int PEND_MAX    = 8;
  localparam int BURST_COUNT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic all_idle = 1'b1;
  logic pwr_down = 1'b0;
  logic sr_req = 1'b0;
  logic burst_mode = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, busy, urgent;

  sdram_refresh_sched #(.TICK_DIV(TICK_DIV), .TRC(TRC), .PEND_MAX(PEND_MAX),
                        .BURST_COUNT(BURST_COUNT)) u0 (
    .clk(clk), .rst_n(rst_n), .all_idle(all_idle), .pwr_down(pwr_down),
    .sr_req(sr_req), .burst_mode(burst_mode), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .busy(busy), .urgent(urgent));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ref_times[$];
  int sre_cnt = 0;
  int last_cmd = -1000;
  int rise_cyc = -1000;
  int r0 = 0;
  logic cke_prev = 1'b1;
  bit done = 0;

  wire is_ref  = ({cs_n, ras_n, cas_n, we_n} == 4'b0001) && cke;
  wire is_sre  = ({cs_n, ras_n, cas_n, we_n} == 4'b0001) && !cke;
  wire non_nop = ({cs_n, ras_n, cas_n, we_n} != 4'b0111);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (is_ref) ref_times.push_back(cyc);
      if (is_sre) sre_cnt++;
      if (non_nop) begin
        chk(cyc - last_cmd >= TRC, "R5 command spacing", cyc - last_cmd, TRC);
        chk(cyc - rise_cyc >= TRC, "R8 exit quiet period", cyc - rise_cyc, TRC);
        last_cmd = cyc;
      end
      if (cke && !cke_prev) rise_cyc = cyc;
      cke_prev = cke;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic align(input int off);
    while (((cyc - r0) % TICK_DIV) != off) step();
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      report();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11 pins NOP", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(cke == 1'b1, "R11 cke high", cke, 1);
    chk(busy == 1'b0, "R11 busy low", busy, 0);
    chk(urgent == 1'b0, "R11 urgent low", urgent, 0);

    // R1 periodic refresh with a free bus
    while (ref_times.size() < 5) step();
    for (int i = 1; i < 5; i++)
      chk(ref_times[i] - ref_times[i-1] == TICK_DIV, "R1 refresh interval",
          ref_times[i] - ref_times[i-1], TICK_DIV);
    r0 = ref_times[0];

    // R2/R3/R4 sweep: block the bus for k whole ticks, then release
    for (int k = 0; k <= 10; k++) begin
      int n0;
      align(5);
      n0 = ref_times.size();
      all_idle = 1'b0;
      repeat (k * TICK_DIV) step();
      chk(ref_times.size() == n0, "R4 no refresh while banks busy", ref_times.size() - n0, 0);
      chk(urgent == (k >= PEND_MAX), "R3 urgent at saturation", urgent, (k >= PEND_MAX));
      all_idle = 1'b1;
      repeat (30) step();
      chk(ref_times.size() - n0 == ((k < PEND_MAX) ? k : PEND_MAX), "R2 stored ticks served",
          ref_times.size() - n0, (k < PEND_MAX) ? k : PEND_MAX);
      chk(urgent == 1'b0, "R3 urgent clears", urgent, 0);
    end

    // R4 power-down gating, R5 busy during hold
    begin
      int n0;
      align(5);
      n0 = ref_times.size();
      pwr_down = 1'b1;
      repeat (3 * TICK_DIV) step();
      chk(ref_times.size() == n0, "R4 no refresh in power-down", ref_times.size() - n0, 0);
      pwr_down = 1'b0;
      repeat (2) step();
      chk(busy == 1'b1, "R5 busy while holding", busy, 1);
      repeat (28) step();
      chk(ref_times.size() - n0 == 3, "R4 refreshes after power-down", ref_times.size() - n0, 3);
      chk(busy == 1'b0, "R5 busy released", busy, 0);
    end

    // R6 entry gated by busy banks; entry beats a pending refresh
    begin
      int n0, s0, lows, bad;
      align(5);
      sr_req = 1'b1;
      all_idle = 1'b0;
      lows = 0;
      repeat (TICK_DIV) begin step(); if (!cke) lows++; end
      chk(lows == 0, "R6 no entry while banks busy", lows, 0);
      n0 = ref_times.size();
      s0 = sre_cnt;
      all_idle = 1'b1;
      repeat (3) step();
      chk(sre_cnt - s0 == 1, "R6 entry issued", sre_cnt - s0, 1);
      chk(ref_times.size() == n0, "R6 entry before pending refresh", ref_times.size() - n0, 0);
      chk(cke == 1'b0, "R6 cke low", cke, 0);
      bad = 0;
      repeat (70) begin step(); if (cke || non_nop) bad++; end
      align(5);
      chk(bad == 0, "R7 quiet in self-refresh", bad, 0);
      chk(ref_times.size() == n0, "R7 ticks ignored", ref_times.size() - n0, 0);
      // exit without burst
      burst_mode = 1'b0;
      sr_req = 1'b0;
      step();
      chk(cke == 1'b1, "R8 cke restored", cke, 1);
      repeat (25) step();
      chk(ref_times.size() == n0, "R9 pending cleared on entry", ref_times.size() - n0, 0);
      align(5);
      chk(ref_times.size() - n0 == 1, "R9 next tick refreshes", ref_times.size() - n0, 1);
    end

    // R10 burst after exit
    begin
      int n0;
      align(5);
      burst_mode = 1'b1;
      sr_req = 1'b1;
      repeat (10) step();
      align(5);
      n0 = ref_times.size();
      sr_req = 1'b0;
      repeat (28) step();
      chk(ref_times.size() - n0 == BURST_COUNT, "R10 burst length", ref_times.size() - n0, BURST_COUNT);
      if (ref_times.size() - n0 == BURST_COUNT) begin
        chk(ref_times[n0] - rise_cyc == TRC, "R10 first burst refresh", ref_times[n0] - rise_cyc, TRC);
        chk(ref_times[n0+BURST_COUNT-1] - ref_times[n0] == (BURST_COUNT - 1) * TRC, "R10 burst spacing",
            ref_times[n0+BURST_COUNT-1] - ref_times[n0], (BURST_COUNT - 1) * TRC);
      end
      chk(busy == 1'b0, "R5 busy released after burst", busy, 0);
      burst_mode = 1'b0;
    end

    // R6 power-down blocks entry
    begin
      int lows;
      align(5);
      pwr_down = 1'b1;
      sr_req = 1'b1;
      lows = 0;
      repeat (10) begin step(); if (!cke) lows++; end
      chk(lows == 0, "R6 no entry in power-down", lows, 0);
      sr_req = 1'b0;
      pwr_down = 1'b0;
      repeat (5) step();
    end

    done = 1;
    report();
  end
endmodule